// File: doc/BRIEF.md
# Control/Status Register Access Unit

This block executes the six register-access instruction forms of a processor against a small bank of control and status registers. Each form reads the old value of the addressed register and hands it back for the destination register. The write forms replace the register with the operand, the set forms OR the operand in, and the clear forms remove the operand's bits. The operand is either a full-width register value or a 5-bit immediate that is zero-extended.

The bank holds three registers:
- a free scratch register;
- a status register with a few writable control bits and a constant field that reports the user-mode register width;
- a cycle counter that software can read but not write.

Every access is checked against the address's read-only marking and against its minimum privilege level. An access that breaks either rule raises an illegal-instruction flag. A faulting access changes no state and does not enable the destination write. The decode is combinational in the cycle the operation is presented, and the register update takes effect at the next rising clock edge.

Top module: `csr_unit`

## Requirements
- R1: `op_i[1:0]` selects the form: 00 is no operation, 01 is write, 10 is set and 11 is clear. `op_i[2]`=1 selects the immediate operand. A legal write form returns the old register value on `rd_data_o` and replaces the register with the operand.
- R2: A legal set form returns the old value and leaves `old | operand`.
- R3: A legal clear form returns the old value and leaves `old & ~operand`.
- R4: Immediate forms use `zimm_i` zero-extended to XLEN bits in place of `rs1_val_i`.
- R5: Outputs are combinational in the cycle the operation is presented. A register update is visible to an access in the following cycle. `rd_we_o` is 1 exactly for a legal non-NOP access.
- R6: A set or clear with `src_zero_i`=1 performs no write. Such an access does not fault on a read-only register, and it returns the register value.
- R7: A write form (including one with a zero operand), or a set or clear with `src_zero_i`=0, raises `illegal_o` when `addr_i[11:10]`=11. In that case the bank keeps its contents, `rd_we_o`=0 and `rd_data_o`=0.
- R8: Privilege is encoded as 00 user, 01 supervisor and 11 machine. An access with `priv_i` numerically below `addr_i[9:8]` raises `illegal_o`, with no state change.
- R9: Only three addresses are implemented: 0x140 scratch, 0x100 status and 0xC00 cycle. Any other address raises `illegal_o`.
- R10: In the status register only bits 1, 5, 8, 18 and 19 are writable. Bits [33:32] read 2 when XLEN is 64 and user mode exists, and read 0 otherwise. Every other bit reads 0.
- R11: The cycle counter resets to 0 and increments on every clock. It is readable from every privilege level.
- R12: After reset the scratch register and the writable status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation: [2] selects the immediate operand, [1:0] gives the form |
| addr_i | input | 12 | Register address |
| rs1_val_i | input | XLEN | Register operand |
| zimm_i | input | 5 | Immediate operand |
| src_zero_i | input | 1 | Operand comes from register x0 or is immediate 0 |
| priv_i | input | 2 | Current privilege level |
| rd_data_o | output | XLEN | Old register value for the destination |
| rd_we_o | output | 1 | Destination write enable |
| illegal_o | output | 1 | Illegal-instruction flag |

## Verification
The bench first replays the known scratch sequences from 3 and from 0xbad1dea, then runs random mixes of forms, privileges and addresses against a bench-side model. Several corner cases get their own directed checks:
- A write of zero to the cycle counter must fault, while a zero-operand set on it must not. A design that counts any set as a write would trap on plain counter reads.
- A user-level read of status must fault, which a missing privilege compare would let through.
- A clear that faults must leave scratch untouched, which a design that updates before checking would corrupt.
- The width field of status must survive an all-ones write, so a design that stores the whole register would let it change.

// File: rtl/csr_pkg.sv
package csr_pkg;

    typedef enum logic [1:0] {
        CSR_NOP = 2'b00,
        CSR_WR  = 2'b01,
        CSR_SET = 2'b10,
        CSR_CLR = 2'b11
    } csr_kind_e;

    typedef struct packed {
        logic      imm;
        csr_kind_e kind;
    } csr_op_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_SCRATCH,
        SEL_STATUS,
        SEL_CYCLE
    } csr_sel_e;

    localparam logic [11:0] ADDR_SCRATCH = 12'h140;
    localparam logic [11:0] ADDR_STATUS  = 12'h100;
    localparam logic [11:0] ADDR_CYCLE   = 12'hC00;

    localparam logic [1:0] PRIV_U = 2'b00;
    localparam logic [1:0] PRIV_S = 2'b01;
    localparam logic [1:0] PRIV_M = 2'b11;

    function automatic logic addr_read_only(input logic [11:0] a);
        return a[11:10] == 2'b11;
    endfunction

    function automatic logic [1:0] addr_min_priv(input logic [11:0] a);
        return a[9:8];
    endfunction

    function automatic csr_sel_e addr_select(input logic [11:0] a);
        case (a)
            ADDR_SCRATCH: return SEL_SCRATCH;
            ADDR_STATUS:  return SEL_STATUS;
            ADDR_CYCLE:   return SEL_CYCLE;
            default:      return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/csr_decode.sv
module csr_decode
    import csr_pkg::*;
(
    input  csr_op_t     op,
    input  logic [11:0] addr,
    input  logic        src_zero,
    input  logic [1:0]  priv,
    output csr_sel_e    sel,
    output logic        active,
    output logic        illegal,
    output logic        do_write
);
    logic wants_write;
    logic ro_fault;
    logic priv_fault;

    always_comb begin
        sel         = addr_select(addr);
        active      = op.kind != CSR_NOP;
        wants_write = (op.kind == CSR_WR) || !src_zero;
        ro_fault    = wants_write && addr_read_only(addr);
        priv_fault  = priv < addr_min_priv(addr);
        illegal     = active && (sel == SEL_NONE || ro_fault || priv_fault);
        do_write    = active && wants_write && !illegal;
    end
endmodule

// File: rtl/csr_regfile.sv
module csr_regfile
    import csr_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter bit HAS_USER = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  csr_sel_e        sel,
    input  csr_kind_e       kind,
    input  logic            do_write,
    input  logic [XLEN-1:0] operand,
    output logic [XLEN-1:0] old_val
);
    localparam logic [XLEN-1:0] STAT_WMASK =
        XLEN'((64'd1 << 1) | (64'd1 << 5) | (64'd1 << 8) | (64'd1 << 18) | (64'd1 << 19));

    logic [XLEN-1:0] scratch_q;
    logic [XLEN-1:0] stat_q;
    logic [XLEN-1:0] cyc_q;
    logic [XLEN-1:0] stat_fixed;
    logic [XLEN-1:0] new_val;

    generate
        if (XLEN == 64) begin : g_width_field
            assign stat_fixed = HAS_USER ? (XLEN'(2) << 32) : '0;
        end else begin : g_no_width_field
            assign stat_fixed = '0;
        end
    endgenerate

    always_comb begin
        case (sel)
            SEL_SCRATCH: old_val = scratch_q;
            SEL_STATUS:  old_val = (stat_q & STAT_WMASK) | stat_fixed;
            SEL_CYCLE:   old_val = cyc_q;
            default:     old_val = '0;
        endcase
        case (kind)
            CSR_WR:  new_val = operand;
            CSR_SET: new_val = old_val | operand;
            CSR_CLR: new_val = old_val & ~operand;
            default: new_val = old_val;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scratch_q <= '0;
            stat_q    <= '0;
            cyc_q     <= '0;
        end else begin
            cyc_q <= cyc_q + 1'b1;
            if (do_write && sel == SEL_SCRATCH) scratch_q <= new_val;
            if (do_write && sel == SEL_STATUS)  stat_q    <= new_val & STAT_WMASK;
        end
    end
endmodule

// File: rtl/csr_unit.sv
module csr_unit
    import csr_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter bit HAS_USER = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [2:0]      op_i,
    input  logic [11:0]     addr_i,
    input  logic [XLEN-1:0] rs1_val_i,
    input  logic [4:0]      zimm_i,
    input  logic            src_zero_i,
    input  logic [1:0]      priv_i,
    output logic [XLEN-1:0] rd_data_o,
    output logic            rd_we_o,
    output logic            illegal_o
);
    csr_op_t         op;
    csr_sel_e        sel;
    logic            active;
    logic            illegal;
    logic            do_write;
    logic [XLEN-1:0] operand;
    logic [XLEN-1:0] old_val;

    assign op      = csr_op_t'(op_i);
    assign operand = op.imm ? XLEN'(zimm_i) : rs1_val_i;

    csr_decode u_dec (
        .op       (op),
        .addr     (addr_i),
        .src_zero (src_zero_i),
        .priv     (priv_i),
        .sel      (sel),
        .active   (active),
        .illegal  (illegal),
        .do_write (do_write)
    );

    csr_regfile #(.XLEN(XLEN), .HAS_USER(HAS_USER)) u_rf (
        .clk      (clk),
        .rst      (rst),
        .sel      (sel),
        .kind     (op.kind),
        .do_write (do_write),
        .operand  (operand),
        .old_val  (old_val)
    );

    assign illegal_o = illegal;
    assign rd_we_o   = active && !illegal;
    assign rd_data_o = illegal ? '0 : old_val;
endmodule

// File: rtl/csr_unit_chk.sv
module csr_unit_chk #(
    parameter int XLEN     = 64,
    parameter bit HAS_USER = 1'b1
) (
    input logic            clk,
    input logic            rst,
    input logic [2:0]      op_i,
    input logic [11:0]     addr_i,
    input logic            src_zero_i,
    input logic [1:0]      priv_i,
    input logic [XLEN-1:0] rd_data_o,
    input logic            rd_we_o,
    input logic            illegal_o,
    input logic [XLEN-1:0] scr_i,
    input logic [XLEN-1:0] cyc_i
);
    logic rd_st;
    assign rd_st = rd_we_o && addr_i == 12'h100;

    // R7
    illegal_keeps_scratch_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_o |=> $stable(scr_i));

    // R6
    zero_set_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i[1] && src_zero_i) |=> $stable(scr_i));

    // R7
    ro_write_faults_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i[1:0] == 2'b01 && addr_i[11:10] == 2'b11) |-> (illegal_o && !rd_we_o));

    // R8
    low_priv_faults_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i[1:0] != 2'b00 && priv_i < addr_i[9:8]) |-> illegal_o);

    // R11
    cycle_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> cyc_i == $past(cyc_i) + 1'b1);

    // R10
    width_field_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_st && XLEN == 64) |-> rd_data_o[XLEN-1:XLEN-32] == (HAS_USER ? 32'd2 : 32'd0));
endmodule

bind csr_unit csr_unit_chk #(.XLEN(XLEN), .HAS_USER(HAS_USER)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_i       (op_i),
    .addr_i     (addr_i),
    .src_zero_i (src_zero_i),
    .priv_i     (priv_i),
    .rd_data_o  (rd_data_o),
    .rd_we_o    (rd_we_o),
    .illegal_o  (illegal_o),
    .scr_i      (u_rf.scratch_q),
    .cyc_i      (u_rf.cyc_q)
);

// File: tb/test_csr_unit.sv
module test_csr_unit;
    localparam int XLEN = 64;
    localparam logic [63:0] WMASK = 64'h00000000000C0122;
    localparam logic [63:0] FIXED = 64'h0000000200000000;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [2:0]      op_i = '0;
    logic [11:0]     addr_i = '0;
    logic [XLEN-1:0] rs1_val_i = '0;
    logic [4:0]      zimm_i = '0;
    logic            src_zero_i = 1'b0;
    logic [1:0]      priv_i = 2'b11;
    logic [XLEN-1:0] rd_data_o;
    logic            rd_we_o;
    logic            illegal_o;

    int total = 0;
    int bad   = 0;
    logic [63:0] s_data;
    logic        s_we, s_ill;
    logic [63:0] m_scr, m_st;

    always #4 clk = ~clk;

    csr_unit #(.XLEN(XLEN), .HAS_USER(1'b1)) i_csr_unit (.*);

    initial begin
        #1600000;
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic [2:0] op, input logic [11:0] addr,
                         input logic [63:0] val, input logic [4:0] zi, input logic [1:0] pv);
        @(negedge clk);
        op_i = op; addr_i = addr; rs1_val_i = val; zimm_i = zi; priv_i = pv;
        src_zero_i = op[2] ? (zi == 5'd0) : (val == 64'd0);
        #2;
        s_data = rd_data_o; s_we = rd_we_o; s_ill = illegal_o;
        @(posedge clk);
        #1;
        op_i = '0;
    endtask

    function automatic logic [63:0] apply(input logic [1:0] k, input logic [63:0] o, input logic [63:0] v);
        case (k)
            2'b01:   return v;
            2'b10:   return o | v;
            2'b11:   return o & ~v;
            default: return o;
        endcase
    endfunction

    function automatic logic exp_ill(input logic [1:0] k, input logic [11:0] a,
                                     input logic z, input logic [1:0] pv);
        logic known, wr;
        known = (a == 12'h140) || (a == 12'h100) || (a == 12'hC00);
        wr = (k == 2'b01) || !z;
        return (k != 2'b00) && (!known || pv < a[9:8] || (wr && a[11:10] == 2'b11));
    endfunction

    logic [63:0] c1;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R12 reset state
        do_op(3'b010, 12'h140, 0, 0, 2'b11);
        chk("R12 scratch reset", s_data, 0);
        do_op(3'b010, 12'h100, 0, 0, 2'b11);
        chk("R12 status reset", s_data, FIXED);

        // R4 R1 R2 R3 immediate sequence
        do_op(3'b101, 12'h140, 0, 5'd3, 2'b11);
        do_op(3'b010, 12'h140, 0, 0, 2'b11);
        chk("R4 imm write", s_data, 3);
        do_op(3'b111, 12'h140, 0, 5'd1, 2'b11);
        chk("R3 clear imm old", s_data, 3);
        do_op(3'b110, 12'h140, 0, 5'd4, 2'b11);
        chk("R2 set imm old", s_data, 2);
        do_op(3'b101, 12'h140, 0, 5'd2, 2'b11);
        chk("R1 write imm old", s_data, 6);
        do_op(3'b001, 12'h140, 64'hbad1dea, 0, 2'b01);
        chk("R1 write reg old", s_data, 2);
        chk("R5 rd_we legal", {63'd0, s_we}, 1);
        do_op(3'b011, 12'h140, 64'h0001dea, 0, 2'b01);
        chk("R3 clear reg old", s_data, 64'hbad1dea);
        do_op(3'b010, 12'h140, 64'h000beef, 0, 2'b01);
        chk("R2 set reg old", s_data, 64'hbad0000);
        do_op(3'b010, 12'h140, 0, 0, 2'b01);
        chk("R2 set result", s_data, 64'hbadbeef);
        do_op(3'b101, 12'h140, 0, 5'h1f, 2'b11);
        do_op(3'b010, 12'h140, 0, 0, 2'b11);
        chk("R4 zero extension", s_data, 64'h1f);

        // R7 write to cycle counter
        do_op(3'b001, 12'hC00, 0, 0, 2'b11);
        chk("R7 cycle write faults", {63'd0, s_ill}, 1);
        chk("R7 no rd write", {63'd0, s_we}, 0);
        chk("R7 rd data zero", s_data, 0);
        do_op(3'b011, 12'h140, 64'hff, 0, 2'b00);
        chk("R8 user clear scratch faults", {63'd0, s_ill}, 1);
        do_op(3'b010, 12'h140, 0, 0, 2'b11);
        chk("R7 R8 scratch kept", s_data, 64'h1f);

        // R6 zero-operand set on read-only
        do_op(3'b110, 12'hC00, 0, 5'd0, 2'b00);
        chk("R6 zero set legal", {63'd0, s_ill}, 0);
        chk("R6 zero set rd_we", {63'd0, s_we}, 1);
        do_op(3'b011, 12'hC00, 64'd5, 0, 2'b00);
        chk("R7 nonzero clear faults", {63'd0, s_ill}, 1);

        // R11 counter
        do_op(3'b010, 12'hC00, 0, 0, 2'b00);
        c1 = s_data;
        do_op(3'b000, 12'h0, 0, 0, 2'b00);
        do_op(3'b000, 12'h0, 0, 0, 2'b00);
        do_op(3'b010, 12'hC00, 0, 0, 2'b00);
        chk("R11 cycle step", s_data - c1, 3);

        // R8 user reading status
        do_op(3'b010, 12'h100, 0, 0, 2'b00);
        chk("R8 user status read", {63'd0, s_ill}, 1);
        // R9 unknown address
        do_op(3'b010, 12'h7C0, 0, 0, 2'b11);
        chk("R9 unknown address", {63'd0, s_ill}, 1);
        // R10 status mask and width field
        do_op(3'b001, 12'h100, 64'hffffffffffffffff, 0, 2'b01);
        do_op(3'b010, 12'h100, 0, 0, 2'b01);
        chk("R10 status all-ones", s_data, WMASK | FIXED);
        // R5 NOP
        do_op(3'b000, 12'h140, 64'h9, 0, 2'b11);
        chk("R5 nop no rd_we", {62'd0, s_we, s_ill}, 0);

        // random mix
        m_scr = 64'h1f; m_st = WMASK;
        void'($urandom(32'd2024));
        for (int i = 0; i < 400; i++) begin
            logic [2:0] op; logic [11:0] a; logic [63:0] v; logic [4:0] zi;
            logic [1:0] pv; logic z, ei; logic [63:0] opd, old;
            int r;
            op = 3'($urandom);
            r = $urandom_range(0, 3);
            a = (r == 0) ? 12'h140 : (r == 1) ? 12'h100 : (r == 2) ? 12'hC00 : 12'h240;
            v = {$urandom, $urandom};
            if ($urandom_range(0, 3) == 0) v = 0;
            zi = 5'($urandom);
            r = $urandom_range(0, 2);
            pv = (r == 0) ? 2'b00 : (r == 1) ? 2'b01 : 2'b11;
            z = op[2] ? (zi == 0) : (v == 0);
            opd = op[2] ? {59'd0, zi} : v;
            ei = exp_ill(op[1:0], a, z, pv);
            do_op(op, a, v, zi, pv);
            chk("R8 R9 random fault", {63'd0, s_ill}, {63'd0, ei});
            chk("R5 random rd_we", {63'd0, s_we}, {63'd0, (op[1:0] != 0) && !ei});
            if (!ei && op[1:0] != 0 && a != 12'hC00) begin
                old = (a == 12'h140) ? m_scr : (m_st | FIXED);
                chk("R1 R2 R3 random old", s_data, old);
                if (op[1:0] == 2'b01 || !z) begin
                    if (a == 12'h140) m_scr = apply(op[1:0], old, opd);
                    else m_st = apply(op[1:0], old, opd) & WMASK;
                end
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule